// File: doc/BRIEF.md
# Converter Channel Scan Sequencer

This block paces a single shared 12-bit analog-to-digital converter that several analog quantities reach through a multiplexer. A prescaler derived from the system clock marks a conversion frame every 2 ms (500 frames per second). At each frame boundary, if no conversion is in flight and the block is not halted, it decodes a 3-bit channel code. It then drives the converter's input select and sense gain, and issues a one-cycle start pulse. When the converter raises its done handshake, the block stores the 12-bit result in one of five result slots: load-current sense, common-mode input, output voltage, set-point voltage or die temperature.

Three of the codes select the same sense input at gains of 1x, 4x and 8x. These correspond to full scales of 440 mV, 110 mV and 55 mV. The gain used is stored next to each sense result. One code makes the block cycle through all five inputs, one per frame. In that mode the sense input uses the gain that was selected most recently. The temperature result is a 9-bit two's-complement value at 0.48 °C per step. It is kept left-aligned in its 12-bit slot.

Top module: `adc_scan_sequencer`

## Requirements
- R1: Channel code 0, 1 and 2 drive convSel = 0 (sense) with convGain = 0, 1 and 2 (1x, 4x, 8x). Code 3 drives convSel = 1 (common-mode), code 4 drives convSel = 2 (output), code 5 drives convSel = 3 (set-point) and code 6 drives convSel = 4 (temperature). All non-sense selections drive convGain = 0.
- R2: A start pulse lasts exactly one cycle. It is issued only at a frame boundary, one every TICK_CYCLES clocks, and only when no conversion is in flight. A boundary that falls inside a conversion is skipped.
- R3: A done pulse during a conversion writes all 12 bits of dataIn into the slot of that conversion's channel on the same clock edge. The slot is visible from the next cycle. No other slot changes.
- R4: A channel-code change during a conversion does not redirect that conversion's result. The new code takes effect at the next start.
- R5: While shutdown is high, no start pulse is issued and the frame counter is held at zero. After shutdown clears, frames resume from a fresh count.
- R6: A conversion that is in flight when shutdown rises still completes into its slot.
- R7: The temperature slot keeps dataIn bits 11:3 and holds bits 2:0 at zero.
- R8: senseGain is updated together with every sense result. It holds the gain code used for that conversion.
- R9: Code 7 visits sense, common-mode, output, set-point and temperature in that order, one per start, and then wraps. The scan always begins at sense. The sense step uses the last gain code (0 to 2) that was applied, which is 1x after reset.
- R10: A done pulse while no conversion is in flight is ignored.
- R11: After reset, every slot, senseGain, convSel and convGain is zero and no start pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chanSel | input | 3 | Channel code from the control register |
| shutdown | input | 1 | Halts new conversions while high |
| startPulse | output | 1 | One-cycle converter start |
| convSel | output | 3 | Analog input select for the running conversion |
| convGain | output | 2 | Sense gain for the running conversion |
| doneIn | input | 1 | Converter done strobe |
| dataIn | input | 12 | Converter result, valid with doneIn |
| senseData | output | 12 | Sense result slot |
| senseGain | output | 2 | Gain code of the stored sense result |
| cmData | output | 12 | Common-mode result slot |
| outData | output | 12 | Output-voltage result slot |
| setData | output | 12 | Set-point result slot |
| tempData | output | 12 | Temperature result slot (left-aligned 9 bits) |

## Verification
The bench changes the channel code in the middle of a conversion. A design that decoded the code at completion instead of at start would write the common-mode result into the output slot. It raises shutdown while a conversion runs, which catches a design that abandons the pending result or keeps launching conversions. It enters the scan after selecting 8x and checks both the visiting order and the reused gain, which exposes a scan pointer that starts mid-list or a gain that falls back to 1x. It also uses a converter latency longer than one frame and sends a stray done pulse while idle, so that a design that launches over a busy converter, or that accepts an unsolicited result, shows a slot mismatch.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_SLOTS = 5;
  localparam logic [2:0] CODE_SCAN = 3'd7;
  localparam logic [2:0] CODE_MAX_GAIN = 3'd2;

  typedef enum logic [2:0] {
    SLOT_SENSE = 3'd0,
    SLOT_CM    = 3'd1,
    SLOT_OUT   = 3'd2,
    SLOT_SET   = 3'd3,
    SLOT_TEMP  = 3'd4
  } slot_e;

  typedef struct packed {
    logic       wrEn;
    slot_e      slot;
    logic [1:0] gain;
  } slot_wr_t;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int TICK_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  output logic tick
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (halt)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = !halt && (cnt == LAST);

  // R5: a halted cycle leaves the frame count at zero
  assert_halt_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halt) |-> (cnt == '0));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] chanSel,
  input  logic       doneIn,
  output logic       startPulse,
  output slot_e      convSel,
  output logic [1:0] convGain,
  output slot_wr_t   wr
);
  logic       busy;
  logic [2:0] scanIdx;
  logic [1:0] lastGain;
  slot_e      nextSlot;
  logic [1:0] nextGain;
  logic       launch;
  logic       accept;

  always_comb begin
    nextSlot = SLOT_SENSE;
    nextGain = 2'd0;
    case (chanSel)
      3'd0, 3'd1, 3'd2: begin
        nextSlot = SLOT_SENSE;
        nextGain = chanSel[1:0];
      end
      3'd3: nextSlot = SLOT_CM;
      3'd4: nextSlot = SLOT_OUT;
      3'd5: nextSlot = SLOT_SET;
      3'd6: nextSlot = SLOT_TEMP;
      default: begin
        nextSlot = slot_e'(scanIdx);
        nextGain = (scanIdx == 3'd0) ? lastGain : 2'd0;
      end
    endcase
  end

  assign launch = tick && !busy;
  assign accept = doneIn && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      startPulse <= 1'b0;
      convSel    <= SLOT_SENSE;
      convGain   <= 2'd0;
      scanIdx    <= 3'd0;
      lastGain   <= 2'd0;
    end else begin
      startPulse <= launch;
      if (launch) begin
        busy     <= 1'b1;
        convSel  <= nextSlot;
        convGain <= nextGain;
      end else if (accept) begin
        busy <= 1'b0;
      end
      if (chanSel != CODE_SCAN)
        scanIdx <= 3'd0;
      else if (launch)
        scanIdx <= (scanIdx == 3'(NUM_SLOTS - 1)) ? 3'd0 : scanIdx + 3'd1;
      if (chanSel <= CODE_MAX_GAIN)
        lastGain <= chanSel[1:0];
    end
  end

  always_comb begin
    wr.wrEn = accept;
    wr.slot = convSel;
    wr.gain = convGain;
  end

  // R2: start lasts one cycle
  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> !startPulse);
  // R2: start only follows a frame boundary from the prescaler
  assert_start_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |-> $past(tick));
  // R1: the input select never leaves the five legal channels
  assert_sel_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    convSel <= SLOT_TEMP);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_seq_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int TEMP_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_wr_t         wr,
  input  logic [RES_W-1:0] dataIn,
  output logic [RES_W-1:0] senseData,
  output logic [1:0]       senseGain,
  output logic [RES_W-1:0] cmData,
  output logic [RES_W-1:0] outData,
  output logic [RES_W-1:0] setData,
  output logic [RES_W-1:0] tempData
);
  localparam int PAD = RES_W - TEMP_W;

  logic [RES_W-1:0] slotQ [NUM_SLOTS];
  logic [RES_W-1:0] tempWord;

  assign tempWord = {dataIn[RES_W-1:PAD], {PAD{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) slotQ[i] <= '0;
      senseGain <= 2'd0;
    end else if (wr.wrEn) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (wr.slot == slot_e'(i))
          slotQ[i] <= (i == int'(SLOT_TEMP)) ? tempWord : dataIn;
      end
      if (wr.slot == SLOT_SENSE) senseGain <= wr.gain;
    end
  end

  assign senseData = slotQ[SLOT_SENSE];
  assign cmData    = slotQ[SLOT_CM];
  assign outData   = slotQ[SLOT_OUT];
  assign setData   = slotQ[SLOT_SET];
  assign tempData  = slotQ[SLOT_TEMP];

  // R10: without a write strobe no slot moves
  assert_slots_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr.wrEn |=> $stable({senseData, cmData, outData, setData, tempData, senseGain}));
endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer
  import adc_seq_pkg::*;
#(
  parameter int CLK_HZ    = 125000000,
  parameter int SAMPLE_HZ = 500,
  parameter int RES_W     = 12,
  parameter int TEMP_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       chanSel,
  input  logic             shutdown,
  output logic             startPulse,
  output logic [2:0]       convSel,
  output logic [1:0]       convGain,
  input  logic             doneIn,
  input  logic [RES_W-1:0] dataIn,
  output logic [RES_W-1:0] senseData,
  output logic [1:0]       senseGain,
  output logic [RES_W-1:0] cmData,
  output logic [RES_W-1:0] outData,
  output logic [RES_W-1:0] setData,
  output logic [RES_W-1:0] tempData
);
  localparam int TICK_CYCLES = CLK_HZ / SAMPLE_HZ;

  logic     tick;
  slot_e    selQ;
  slot_wr_t wr;

  adc_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .halt(shutdown), .tick(tick)
  );

  adc_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .chanSel(chanSel), .doneIn(doneIn),
    .startPulse(startPulse), .convSel(selQ), .convGain(convGain), .wr(wr)
  );

  adc_result_bank #(.RES_W(RES_W), .TEMP_W(TEMP_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(wr), .dataIn(dataIn),
    .senseData(senseData), .senseGain(senseGain), .cmData(cmData),
    .outData(outData), .setData(setData), .tempData(tempData)
  );

  assign convSel = selQ;

  // R5: no start follows a cycle in which shutdown was high
  assert_no_start_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |-> !$past(shutdown));
endmodule

// File: tb/sim_adc_scan_sequencer.sv
`timescale 1ns/1ps
module sim_adc_scan_sequencer;
  localparam int CLK_HZ = 125000000;
  localparam int SAMPLE_HZ = 5000000;
  localparam int TICK = CLK_HZ / SAMPLE_HZ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] chanSel = 3'd0;
  logic shutdown = 1'b0;
  logic startPulse, doneIn;
  logic [2:0] convSel;
  logic [1:0] convGain, senseGain;
  logic [11:0] dataIn, senseData, cmData, outData, setData, tempData;

  always #4 clk = ~clk;

  adc_scan_sequencer #(.CLK_HZ(CLK_HZ), .SAMPLE_HZ(SAMPLE_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .chanSel(chanSel), .shutdown(shutdown),
    .startPulse(startPulse), .convSel(convSel), .convGain(convGain),
    .doneIn(doneIn), .dataIn(dataIn), .senseData(senseData),
    .senseGain(senseGain), .cmData(cmData), .outData(outData),
    .setData(setData), .tempData(tempData)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // converter responder
  int convLat = 6;
  int seqNo = 0;
  bit spuriousReq = 0;
  logic [11:0] lastSent = '0;
  initial begin
    doneIn = 1'b0;
    dataIn = '0;
    forever begin
      @(negedge clk);
      if (spuriousReq) begin
        spuriousReq = 0;
        doneIn = 1'b1; dataIn = 12'hFFF;
        @(negedge clk);
        doneIn = 1'b0;
      end else if (startPulse) begin
        repeat (convLat - 1) @(negedge clk);
        seqNo++;
        lastSent = 12'(seqNo * 331 + 7);
        doneIn = 1'b1; dataIn = lastSent;
        @(negedge clk);
        doneIn = 1'b0;
      end
    end
  end

  // behavioural reference, stepped after each rising edge
  int mCnt = 0, mScan = 0, mCur = 0;
  bit mBusy = 0, mStart = 0;
  logic [1:0] mLastGain = 0, mCurGain = 0, mSGain = 0;
  logic [11:0] mSlot [5];
  initial for (int i = 0; i < 5; i++) mSlot[i] = '0;

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      mCnt = 0; mScan = 0; mCur = 0; mBusy = 0; mStart = 0;
      mLastGain = 0; mCurGain = 0; mSGain = 0;
      for (int i = 0; i < 5; i++) mSlot[i] = '0;
    end else begin
      bit tk, acc, lau;
      tk = !shutdown && (mCnt == TICK - 1);
      if (shutdown || mCnt == TICK - 1) mCnt = 0; else mCnt++;
      acc = doneIn && mBusy;
      lau = tk && !mBusy;
      if (acc) begin
        mSlot[mCur] = (mCur == 4) ? (dataIn & 12'hFF8) : dataIn;
        if (mCur == 0) mSGain = mCurGain;
        mBusy = 0;
      end
      if (lau) begin
        if (chanSel <= 2) begin mCur = 0; mCurGain = chanSel[1:0]; end
        else if (chanSel == 7) begin mCur = mScan; mCurGain = (mScan == 0) ? mLastGain : 2'd0; end
        else begin mCur = int'(chanSel) - 2; mCurGain = 2'd0; end
        mBusy = 1;
      end
      mStart = lau;
      if (chanSel != 7) mScan = 0; else if (lau) mScan = (mScan + 1) % 5;
      if (chanSel <= 2) mLastGain = chanSel[1:0];
    end
    check(startPulse == mStart, "R2 startPulse", startPulse, mStart);
    check(convSel == 3'(mCur), "R1 convSel", convSel, mCur);
    check(convGain == mCurGain, "R1 convGain", convGain, mCurGain);
    check(senseData == mSlot[0], "R3 senseData", senseData, mSlot[0]);
    check(senseGain == mSGain, "R8 senseGain", senseGain, mSGain);
    check(cmData == mSlot[1], "R4 cmData", cmData, mSlot[1]);
    check(outData == mSlot[2], "R4 outData", outData, mSlot[2]);
    check(setData == mSlot[3], "R6 setData", setData, mSlot[3]);
    check(tempData == mSlot[4], "R7 tempData", tempData, mSlot[4]);
  end

  task automatic waitStart();
    do @(negedge clk); while (!startPulse);
  endtask

  task automatic waitDone();
    do @(posedge clk); while (!doneIn);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [11:0] snap;
    int starts;
    int expSel [7] = '{0, 1, 2, 3, 4, 0, 1};
    repeat (5) @(negedge clk);
    // R11 reset state
    check(startPulse == 0 && senseData == 0 && tempData == 0 && convSel == 0,
          "R11 reset state", {startPulse, senseData}, 0);
    rst_n = 1'b1;

    // R1 every direct code
    for (int c = 0; c < 7; c++) begin
      chanSel = 3'(c);
      repeat (3 * TICK) @(negedge clk);
    end
    // R7 temperature low bits
    check(tempData[2:0] == 3'b000, "R7 temp low bits", tempData[2:0], 0);

    // R4 code change mid-conversion
    convLat = 15;
    chanSel = 3'd3;
    waitStart();
    check(convSel == 3'd1, "R4 started on common-mode", convSel, 1);
    snap = outData;
    chanSel = 3'd4;
    waitDone();
    check(cmData == lastSent, "R4 result in common-mode slot", cmData, lastSent);
    check(outData == snap, "R4 output slot untouched", outData, snap);
    waitStart();
    check(convSel == 3'd2, "R4 next start uses new code", convSel, 2);

    // R6 in-flight conversion survives shutdown, R5 no starts while halted
    chanSel = 3'd5;
    waitStart();
    shutdown = 1'b1;
    starts = 0;
    for (int i = 0; i < 5 * TICK; i++) begin
      @(negedge clk);
      if (startPulse) starts++;
    end
    check(setData == lastSent, "R6 set-point completes in shutdown", setData, lastSent);
    check(starts == 0, "R5 no start while halted", starts, 0);

    // R10 stray done while idle
    snap = setData;
    spuriousReq = 1;
    repeat (6) @(negedge clk);
    check(setData == snap && senseData != 12'hFFF, "R10 stray done ignored", setData, snap);

    // R9 scan with reused 8x gain
    convLat = 6;
    shutdown = 1'b0;
    chanSel = 3'd2;
    waitStart();
    chanSel = 3'd7;
    for (int k = 0; k < 7; k++) begin
      waitStart();
      check(convSel == 3'(expSel[k]), "R9 scan order", convSel, expSel[k]);
      if (expSel[k] == 0)
        check(convGain == 2'd2, "R9 scan reuses last gain", convGain, 2);
    end
    waitDone();
    check(senseGain == 2'd2, "R8 sense gain tag", senseGain, 2);

    // R2 latency longer than a frame
    convLat = 30;
    chanSel = 3'd1;
    repeat (8 * TICK) @(negedge clk);
    convLat = 6;
    repeat (2 * TICK) @(negedge clk);
    finishRun();
  end
endmodule